// File: doc/BRIEF.md
# Programmable Serial Clock Divider

This block derives the serial clock of a multi-lane SPI controller from a faster base clock. Software programs it through a single control word. The word holds a run bit, a read-only lock indication and a divider field. While the run bit is set, the output toggles every D base cycles, where D is the divider field. A field value of zero counts as one, so the fastest output is half the base clock.

Every write to the control word is treated as a divider rewrite, and it drops the lock indication. A new divider is never applied in the middle of an output level. The half-period that is running when the write lands finishes at the old length, and the new length starts at that boundary. Lock is reported again once a full output period at the new rate has completed, so software can poll the word and wait a bounded time before it starts shifting data. When the run bit is clear, the output rests at the level chosen by the clock-polarity input.

Top module: `serclk_div`

## Requirements
- R1: After reset the control word reads all zeros and the serial clock equals the polarity input.
- R2: Control word fields: bit 0 is the run bit (read/write), bit 1 is the lock flag (read-only, written values ignored), bits 15:8 are the divider D (read/write). All other bits read as zero.
- R3: While running with settled D in 1..255, every output level lasts exactly D base cycles, giving a period of 2·D cycles.
- R4: A divider of 0 gives one-cycle output levels, the same as D = 1 (divide by two).
- R5: While the run bit is clear, the serial clock does not toggle and follows the polarity input. Clearing the run bit returns the output to the polarity level on the next cycle.
- R6: After the run bit is set from the stopped state, the output holds the polarity level for D cycles and then makes its first transition away from it.
- R7: Any write to the control word makes the lock flag read as 0 on the cycle after the write.
- R8: A divider change during running takes effect only at the next half-period boundary. The level in progress finishes at the old length and every later level has the new length.
- R9: The lock flag sets at the boundary that completes two half-periods at the new divider. When started from the stopped state it reads 1 exactly 2·D cycles after the enabling write. After a rewrite while running it is set within old D + 2·new D + 2 cycles.
- R10: The lock flag reads 0 whenever the run bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Control word write strobe |
| wdata_i | input | 16 | Control word write value |
| rdata_o | output | 16 | Control word read value |
| cpol_i | input | 1 | Idle level of the serial clock |
| sclk_o | output | 1 | Divided serial clock |

## Verification
The divider is run at 4, 0, 255 and 3, which covers a middle value, the zero-as-one rule and the widest count. Between them it is changed upward (4 to 7) and downward (255 to 2) part-way through a level, so that a design which reloads at once instead of at the boundary shows up as a wrong first interval. Starting from the stopped state separates the first-edge delay from the lock delay. Rewriting an unchanged divider shows that the lock flag tracks writes rather than value changes. A stopped run with a changing polarity input shows that the output follows the polarity while it does not toggle.

// File: rtl/serclk_pkg.sv
package serclk_pkg;
   // bit positions of the control word fields
   localparam int EN_POS  = 0;
   localparam int STB_POS = 1;
   localparam int DIV_POS = 8;
endpackage

// File: rtl/serclk_ctrl.sv
module serclk_ctrl #(
   parameter  int DIV_W  = 8,
   localparam int WORD_W = serclk_pkg::DIV_POS + DIV_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [WORD_W-1:0] wdata_i,
   input  logic              stable_i,
   output logic              en_o,
   output logic [DIV_W-1:0]  div_o,
   output logic [DIV_W-1:0]  div_nxt_o,
   output logic [WORD_W-1:0] rdata_o
);
   import serclk_pkg::*;

   logic             en_q;
   logic [DIV_W-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         div_q <= '0;
      end else if (wr_i) begin
         en_q  <= wdata_i[EN_POS];
         div_q <= wdata_i[DIV_POS +: DIV_W];
      end
   end

   // value the divider register holds after this edge
   assign div_nxt_o = wr_i ? wdata_i[DIV_POS +: DIV_W] : div_q;
   assign en_o      = en_q;
   assign div_o     = div_q;

   // readback assembly, reserved bits tied low
   for (genvar b = 0; b < WORD_W; b++) begin : g_rd
      if (b == EN_POS) begin : g_en
         assign rdata_o[b] = en_q;
      end else if (b == STB_POS) begin : g_stb
         assign rdata_o[b] = stable_i;
      end else if (b >= DIV_POS) begin : g_div
         assign rdata_o[b] = div_q[b - DIV_POS];
      end else begin : g_rsv
         assign rdata_o[b] = 1'b0;
      end
   end

   // R2: a write lands in the run bit and divider field
   a_r2_write_lands : assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (en_o == $past(wdata_i[EN_POS])) &&
               (div_o == $past(wdata_i[DIV_POS +: DIV_W])));

   // R2: fields hold without a write
   a_r2_fields_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(div_o) && $stable(en_o));
endmodule

// File: rtl/serclk_engine.sv
module serclk_engine #(
   parameter  int DIV_W         = 8,
   parameter  int SETTLE_HALVES = 2,
   localparam int SET_W         = $clog2(SETTLE_HALVES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             wr_i,
   input  logic [DIV_W-1:0] div_nxt_i,
   input  logic             cpol_i,
   output logic             sclk_o,
   output logic             stable_o
);
   localparam logic [SET_W-1:0] SETTLE_V = SET_W'(SETTLE_HALVES);

   logic [DIV_W-1:0] act_q;
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] term_w;
   logic             phase_q;
   logic             pend_q;
   logic [SET_W-1:0] settle_q;
   logic             bnd_w;

   // last count of a half-period; divider 0 behaves as 1
   assign term_w = (act_q == '0) ? '0 : act_q - 1'b1;
   assign bnd_w  = run_i && (cnt_q == term_w);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q    <= '0;
         cnt_q    <= '0;
         phase_q  <= 1'b0;
         pend_q   <= 1'b0;
         settle_q <= '0;
      end else if (!run_i) begin
         act_q    <= div_nxt_i;
         cnt_q    <= '0;
         phase_q  <= 1'b0;
         pend_q   <= 1'b0;
         settle_q <= '0;
      end else if (bnd_w) begin
         act_q   <= div_nxt_i;
         cnt_q   <= '0;
         phase_q <= ~phase_q;
         pend_q  <= 1'b0;
         if (pend_q || wr_i) begin
            settle_q <= '0;
         end else if (settle_q != SETTLE_V) begin
            settle_q <= settle_q + 1'b1;
         end
      end else begin
         cnt_q <= cnt_q + 1'b1;
         if (wr_i) begin
            pend_q   <= 1'b1;
            settle_q <= '0;
         end
      end
   end

   assign sclk_o   = run_i ? (cpol_i ^ phase_q) : cpol_i;
   assign stable_o = run_i && !pend_q && (settle_q == SETTLE_V);

   // R8: the output level changes only when a half-period has ended
   a_r8_edge_at_term : assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && $past(run_i) && (phase_q != $past(phase_q)))
         |-> ($past(cnt_q) == $past(term_w)));

   // R8: the count never passes the end of the current half-period
   a_r8_cnt_range : assert property (@(posedge clk) disable iff (!rst_n)
      run_i |-> (cnt_q <= term_w));

   // R7: a write always removes the lock indication
   a_r7_write_drops : assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> !stable_o);

   // R9: lock rises only right after a half-period boundary
   a_r9_rise_at_edge : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stable_o) |-> $past(bnd_w));

   // R5: stopped output moves only with the polarity input
   a_r5_idle_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && $past(!run_i) && $stable(cpol_i)) |-> $stable(sclk_o));
endmodule

// File: rtl/serclk_div.sv
module serclk_div #(
   parameter int DIV_W         = 8,
   parameter int SETTLE_HALVES = 2
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                wr_i,
   input  logic [serclk_pkg::DIV_POS+DIV_W-1:0] wdata_i,
   output logic [serclk_pkg::DIV_POS+DIV_W-1:0] rdata_o,
   input  logic                                cpol_i,
   output logic                                sclk_o
);
   localparam int WAIT_LIMIT = (SETTLE_HALVES + 2) * (2 ** DIV_W) + 4;
   localparam int WT_W       = $clog2(WAIT_LIMIT + 1);

   if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
      $error("serclk_div: DIV_W must lie in 1..16");
   end
   if (SETTLE_HALVES < 1 || SETTLE_HALVES > 8) begin : g_bad_settle
      $error("serclk_div: SETTLE_HALVES must lie in 1..8");
   end

   logic             run_w;
   logic             stable_w;
   logic [DIV_W-1:0] div_w;
   logic [DIV_W-1:0] div_nxt_w;

   serclk_ctrl #(.DIV_W(DIV_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (wr_i),
      .wdata_i   (wdata_i),
      .stable_i  (stable_w),
      .en_o      (run_w),
      .div_o     (div_w),
      .div_nxt_o (div_nxt_w),
      .rdata_o   (rdata_o)
   );

   serclk_engine #(.DIV_W(DIV_W), .SETTLE_HALVES(SETTLE_HALVES)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run_w),
      .wr_i      (wr_i),
      .div_nxt_i (div_nxt_w),
      .cpol_i    (cpol_i),
      .sclk_o    (sclk_o),
      .stable_o  (stable_w)
   );

   // watch window: cycles spent running without lock since the last write
   logic [WT_W-1:0] wait_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wait_q <= '0;
      end else if (!run_w || stable_w || wr_i) begin
         wait_q <= '0;
      end else if (wait_q != WT_W'(WAIT_LIMIT)) begin
         wait_q <= wait_q + 1'b1;
      end
   end

   // R9: lock returns within a bounded number of cycles
   a_r9_bounded_settle : assert property (@(posedge clk) disable iff (!rst_n)
      wait_q < WT_W'(WAIT_LIMIT));

   // R10: no lock while stopped, observed at the word
   a_r10_stopped_unlocked : assert property (@(posedge clk) disable iff (!rst_n)
      !rdata_o[serclk_pkg::EN_POS] |-> !rdata_o[serclk_pkg::STB_POS]);

   // divider register unused here beyond readback
   logic unused_w;
   assign unused_w = ^div_w;
endmodule

// File: tb/serclk_div_tb.sv
module serclk_div_tb;
   localparam int CLK_PERIOD = 10;
   localparam int W          = 16;
   localparam int WD_CYCLES  = 150000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_i = 1'b0;
   logic [W-1:0] wdata_i = '0;
   logic [W-1:0] rdata_o;
   logic         cpol_i = 1'b0;
   logic         sclk_o;

   serclk_div u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (wr_i),
      .wdata_i (wdata_i),
      .rdata_o (rdata_o),
      .cpol_i  (cpol_i),
      .sclk_o  (sclk_o)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   int    cyc = 0;
   int    last_cyc = 0;
   logic  last_s = 1'b0;
   int    tog_cnt = 0;
   int    iv_m;
   int    exp_m;
   bit    mon_on = 1'b0;
   string mon_tag = "R3";
   int    exp_q[$];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: measures every level length and scores it against the queue
   always @(negedge clk) begin
      if (sclk_o !== last_s) begin
         iv_m     = cyc - last_cyc;
         last_cyc = cyc;
         last_s   = sclk_o;
         tog_cnt++;
         if (mon_on && exp_q.size() > 0) begin
            exp_m = exp_q.pop_front();
            chk(iv_m == exp_m, mon_tag, iv_m, exp_m);
         end
      end
   end

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic wr_word(input logic [W-1:0] v);
      step();
      wr_i    = 1'b1;
      wdata_i = v;
      @(posedge clk);
      #1;
      wr_i = 1'b0;
   endtask

   task automatic push_n(input int len, input int n);
      for (int i = 0; i < n; i++) exp_q.push_back(len);
   endtask

   task automatic wait_stable(output int n);
      n = 0;
      step();
      while (!rdata_o[1] && n < 5000) begin
         n++;
         step();
      end
   endtask

   task automatic wait_toggle();
      int t0 = tog_cnt;
      int g = 0;
      while (tog_cnt == t0 && g < 3000) begin
         step();
         g++;
      end
   endtask

   task automatic drain(input string req);
      int g = 0;
      while (exp_q.size() > 0 && g < 5000) begin
         step();
         g++;
      end
      mon_on = 1'b0;
      chk(exp_q.size() == 0, req, exp_q.size(), 0);
      exp_q.delete();
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         chk(1'b0, "WATCHDOG", cyc, WD_CYCLES);
         summary();
         $finish;
      end
   end

   initial begin
      int n;
      int first;
      int t0;

      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      step();
      // R1: reset state
      chk(rdata_o == 16'h0000, "R1 word", int'(rdata_o), 0);
      chk(sclk_o == cpol_i, "R1 sclk", int'(sclk_o), int'(cpol_i));

      // R2: field placement, lock bit and reserved bits not writable
      wr_word(16'hA5FE);
      step();
      chk(rdata_o == 16'hA500, "R2 readback", int'(rdata_o), 'hA500);
      chk(rdata_o[1] == 1'b0, "R10 stopped lock", int'(rdata_o[1]), 0);
      // R5: no toggles while stopped, output follows polarity
      t0 = tog_cnt;
      repeat (20) step();
      chk(tog_cnt == t0, "R5 quiet", tog_cnt - t0, 0);
      cpol_i = 1'b1;
      step();
      chk(sclk_o == 1'b1, "R5 follows cpol", int'(sclk_o), 1);

      // R6 and R9: start from stopped with D=4
      wr_word(16'h0401);
      n = 0;
      first = -1;
      step();
      while (!rdata_o[1] && n < 5000) begin
         if (first < 0 && sclk_o != cpol_i) first = n;
         n++;
         step();
      end
      chk(first == 4, "R6 first edge", first, 4);
      chk(n == 8, "R9 lock from start", n, 8);

      // R3: steady levels at D=4
      mon_tag = "R3 D=4";
      push_n(4, 6);
      mon_on = 1'b1;
      drain("R3 D=4 drain");

      // R8 and R7: raise 4 -> 7 mid-level
      wait_toggle();
      mon_tag = "R8 grow";
      exp_q.push_back(4);
      push_n(7, 4);
      mon_on = 1'b1;
      wr_word(16'h0701);
      step();
      chk(rdata_o[1] == 1'b0, "R7 lock drop", int'(rdata_o[1]), 0);
      n = 1;
      while (!rdata_o[1] && n < 5000) begin
         step();
         n++;
      end
      chk(n <= 4 + 14 + 2, "R9 lock after change", n, 20);
      drain("R8 grow drain");

      // R4: divider zero runs at one cycle per level
      wr_word(16'h0001);
      wait_stable(n);
      mon_tag = "R4 D=0";
      push_n(1, 6);
      mon_on = 1'b1;
      drain("R4 drain");

      // R3: widest divider
      wr_word(16'hFF01);
      wait_stable(n);
      chk(rdata_o[1] == 1'b1, "R9 lock D=255", int'(rdata_o[1]), 1);
      mon_tag = "R3 D=255";
      push_n(255, 3);
      mon_on = 1'b1;
      drain("R3 D=255 drain");

      // R8: shrink 255 -> 2 mid-level
      wait_toggle();
      mon_tag = "R8 shrink";
      exp_q.push_back(255);
      push_n(2, 3);
      mon_on = 1'b1;
      wr_word(16'h0201);
      drain("R8 shrink drain");

      // R5 and R10: stop while the output is away from idle
      n = 0;
      while (sclk_o == cpol_i && n < 100) begin
         step();
         n++;
      end
      wr_word(16'h0200);
      step();
      chk(sclk_o == cpol_i, "R5 stop to idle", int'(sclk_o), int'(cpol_i));
      chk(rdata_o == 16'h0200, "R10 word after stop", int'(rdata_o), 'h0200);
      t0 = tog_cnt;
      repeat (30) step();
      chk(tog_cnt == t0, "R5 quiet after stop", tog_cnt - t0, 0);
      cpol_i = 1'b0;
      step();
      chk(sclk_o == 1'b0, "R5 follows cpol low", int'(sclk_o), 0);

      // R9 exact start with D=3, then R7 on an unchanged rewrite
      wr_word(16'h0301);
      wait_stable(n);
      chk(n == 6, "R9 lock from start D=3", n, 6);
      wr_word(16'h0301);
      step();
      chk(rdata_o[1] == 1'b0, "R7 same-value rewrite", int'(rdata_o[1]), 0);
      n = 1;
      while (!rdata_o[1] && n < 5000) begin
         step();
         n++;
      end
      chk(n <= 3 + 6 + 2, "R9 relock bound", n, 11);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule